// File: doc/BRIEF.md
# DPLL Phase Detector

This block produces the digital phase error and frequency error for a phase-domain fractional-N digital PLL. Each reference edge delivers one sample. The sample holds the rotational counter value, which is the integer number of oscillator periods, and a 40-bit snapshot from an interpolating time-to-digital converter. That converter watches five oscillator phases, and each phase interval is split by eight delayed copies of the reference. One converter step is therefore one fortieth of an oscillator period, and the full range of 40 steps covers exactly one period.

The block first decodes the snapshot into a fractional phase. It then uses that fraction to correct the integer count, and joins the two into a phase word counted in steps. A frequency command word (FCW) is added to an accumulator on every accepted sample, and the phase error is the measured word minus the accumulated command. A differentiator subtracts the previous measured word and the FCW from the current word, which gives the frequency error used while the loop is acquiring lock. When a lock-start pulse arrives with a sample, the accumulator is loaded with the measured phase so that tracking begins with zero error.

Samples enter on a valid/ready stream and results leave on a valid/ready stream. The block holds one result register. A new sample is accepted only when that register is empty or is being drained in the same cycle. While the output is stalled, the input ready stays low, and the result together with all internal state is frozen.

Top module: `dpll_phase_detector`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and both the accumulator and the stored previous phase are 0. The first accepted sample without a lock pulse therefore reports phase error = frequency error = measured phase − FCW.
- R2: Bit k of `tdc_smp` (k = phase·8 + tap) is 1 for every k below the fractional phase f and 0 from f upward. The decoded fraction f (0..39) is the index of the first 0 bit.
- R3: A single flipped bit at least two positions away from the 1-to-0 edge does not change the decoded fraction. Each bit is filtered by a majority of itself and its two neighbours, with a virtual 1 below bit 0 and a virtual 0 above bit 39.
- R4: A snapshot that is all ones decodes as fraction 39.
- R5: The counter sample is taken half an oscillator period after the converter's instant. The measured integer is therefore `cnt_smp` − 1 when f ≥ 20, and `cnt_smp` otherwise, modulo 2^INT_W.
- R6: The FCW is `fcw_int` periods plus `fcw_frac` steps, with `fcw_frac` in 0..39. Every accepted sample adds the FCW to the accumulator, carrying from the step field into the integer field. `ph_err` is the measured phase minus the new accumulator value, in steps, as two's complement.
- R7: `fr_err` is the measured phase minus the previous accepted measured phase minus the FCW, in steps, as two's complement.
- R8: A sample accepted with `lock_load` = 1 loads the accumulator with its own measured phase and reports `ph_err` = 0. Later samples accumulate from that value.
- R9: Results are registered. They appear with `out_valid` = 1 in the cycle after acceptance, and `out_valid` returns to 0 once they have been taken and no new sample has been accepted.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, no sample is accepted and `ph_err`/`fr_err` hold their values.
- R11: All phase arithmetic wraps modulo 2^INT_W·40 steps. Both errors are reported as the wrapped difference in [−2^(INT_W−1)·40, 2^(INT_W−1)·40).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample can be accepted |
| cnt_smp | input | INT_W | Sampled rotational counter |
| tdc_smp | input | NPH·NTAP | Converter snapshot, bit k = phase·8 + tap |
| fcw_int | input | INT_W | FCW integer periods |
| fcw_frac | input | FRAC_W | FCW fraction in steps, 0..STEPS−1 |
| lock_load | input | 1 | Reload the accumulator from this sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| ph_err | output | ERR_W | Phase error in steps, two's complement |
| fr_err | output | ERR_W | Frequency error in steps, two's complement |

## Verification
Two events can fall in the same cycle: an accumulator reload triggered by a lock pulse, and a stall on the output. The bench provokes this by holding `out_ready` low and presenting a sample with `lock_load` set for several cycles. During that time it checks that `in_ready` stays low and that the previous result stays fixed. After `out_ready` is released, it checks two things. The phase error must be zero, which shows the reload happened exactly once. The frequency error must be measured against the stalled sample, which shows the held sample was never absorbed earlier. Sweeps over every fraction cover the decoder, bubble rejection and correction of the integer count across integer wrap.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int DEF_NPH   = 5;
  localparam int DEF_NTAP  = 8;
  localparam int DEF_INT_W = 8;

  // majority vote of three neighbouring snapshot bits
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/pd_therm_decode.sv
module pd_therm_decode #(
  parameter int STEPS  = 40,
  parameter int FRAC_W = 6
) (
  input  logic [STEPS-1:0]  therm,
  output logic [FRAC_W-1:0] frac
);
  // ext[k+1] = therm[k]; a virtual 1 sits below bit 0 and a virtual 0 above the top bit
  logic [STEPS+1:0] ext;
  logic [STEPS-1:0] filt;

  assign ext = {1'b0, therm, 1'b1};

  for (genvar k = 0; k < STEPS; k++) begin : g_flt
    assign filt[k] = pd_pkg::maj3(ext[k], ext[k+1], ext[k+2]);
  end

  // position of the lowest zero; saturates at STEPS-1 when none is found
  always_comb begin
    frac = FRAC_W'(STEPS - 1);
    for (int k = STEPS - 1; k >= 0; k--) begin
      if (!filt[k]) frac = FRAC_W'(k);
    end
  end
endmodule

// File: rtl/pd_int_align.sv
module pd_int_align #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 6,
  parameter int STEPS  = 40
) (
  input  logic [INT_W-1:0]  cnt,
  input  logic [FRAC_W-1:0] frac,
  output logic [INT_W-1:0]  int_o
);
  localparam int HALF = STEPS / 2;

  logic late;

  // counter is captured half a period after the converter instant
  assign late  = (frac >= FRAC_W'(HALF));
  assign int_o = cnt - INT_W'(late);
endmodule

// File: rtl/pd_mix_arith.sv
module pd_mix_arith #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 6,
  parameter int STEPS  = 40,
  parameter bit SUB    = 1'b0
) (
  input  logic [INT_W-1:0]  a_i,
  input  logic [FRAC_W-1:0] a_f,
  input  logic [INT_W-1:0]  b_i,
  input  logic [FRAC_W-1:0] b_f,
  output logic [INT_W-1:0]  y_i,
  output logic [FRAC_W-1:0] y_f
);
  localparam logic [FRAC_W:0] STEPS_W = (FRAC_W+1)'(STEPS);

  if (SUB) begin : g_sub
    logic brw;
    assign brw = (a_f < b_f);
    assign y_f = FRAC_W'(brw ? ({1'b0, a_f} + STEPS_W - {1'b0, b_f})
                             : ({1'b0, a_f} - {1'b0, b_f}));
    assign y_i = a_i - b_i - INT_W'(brw);
  end else begin : g_add
    logic [FRAC_W:0] s;
    logic            cy;
    assign s   = {1'b0, a_f} + {1'b0, b_f};
    assign cy  = (s >= STEPS_W);
    assign y_f = FRAC_W'(cy ? (s - STEPS_W) : s);
    assign y_i = a_i + b_i + INT_W'(cy);
  end
endmodule

// File: rtl/pd_to_steps.sv
module pd_to_steps #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 6,
  parameter int STEPS  = 40,
  parameter int ERR_W  = 14
) (
  input  logic [INT_W-1:0]  d_i,
  input  logic [FRAC_W-1:0] d_f,
  output logic [ERR_W-1:0]  steps
);
  logic [ERR_W-1:0] ie;

  // signed integer periods times steps per period, plus the step field
  assign ie    = {{FRAC_W{d_i[INT_W-1]}}, d_i};
  assign steps = ie * ERR_W'(STEPS) + {{INT_W{1'b0}}, d_f};
endmodule

// File: rtl/dpll_phase_detector.sv
module dpll_phase_detector #(
  parameter  int NPH    = pd_pkg::DEF_NPH,
  parameter  int NTAP   = pd_pkg::DEF_NTAP,
  parameter  int INT_W  = pd_pkg::DEF_INT_W,
  localparam int STEPS  = NPH * NTAP,
  localparam int FRAC_W = $clog2(STEPS),
  localparam int ERR_W  = INT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INT_W-1:0]  cnt_smp,
  input  logic [STEPS-1:0]  tdc_smp,
  input  logic [INT_W-1:0]  fcw_int,
  input  logic [FRAC_W-1:0] fcw_frac,
  input  logic              lock_load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ERR_W-1:0]  ph_err,
  output logic [ERR_W-1:0]  fr_err
);
  logic              accept;
  logic [FRAC_W-1:0] meas_f;
  logic [INT_W-1:0]  meas_i;
  logic [INT_W-1:0]  acc_i, prev_i, sum_i, nacc_i, pe_i, dl_i, fe_i;
  logic [FRAC_W-1:0] acc_f, prev_f, sum_f, nacc_f, pe_f, dl_f, fe_f;
  logic [ERR_W-1:0]  pe_steps, fe_steps;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  pd_therm_decode #(.STEPS(STEPS), .FRAC_W(FRAC_W)) u_dec (
    .therm(tdc_smp), .frac(meas_f)
  );

  pd_int_align #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEPS(STEPS)) u_align (
    .cnt(cnt_smp), .frac(meas_f), .int_o(meas_i)
  );

  // command accumulator advance
  pd_mix_arith #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEPS(STEPS), .SUB(1'b0)) u_acc_add (
    .a_i(acc_i), .a_f(acc_f), .b_i(fcw_int), .b_f(fcw_frac), .y_i(sum_i), .y_f(sum_f)
  );

  assign nacc_i = lock_load ? meas_i : sum_i;
  assign nacc_f = lock_load ? meas_f : sum_f;

  // phase error
  pd_mix_arith #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEPS(STEPS), .SUB(1'b1)) u_pe_sub (
    .a_i(meas_i), .a_f(meas_f), .b_i(nacc_i), .b_f(nacc_f), .y_i(pe_i), .y_f(pe_f)
  );

  // differentiator, then command removal
  pd_mix_arith #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEPS(STEPS), .SUB(1'b1)) u_dl_sub (
    .a_i(meas_i), .a_f(meas_f), .b_i(prev_i), .b_f(prev_f), .y_i(dl_i), .y_f(dl_f)
  );

  pd_mix_arith #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEPS(STEPS), .SUB(1'b1)) u_fe_sub (
    .a_i(dl_i), .a_f(dl_f), .b_i(fcw_int), .b_f(fcw_frac), .y_i(fe_i), .y_f(fe_f)
  );

  pd_to_steps #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEPS(STEPS), .ERR_W(ERR_W)) u_pe_cv (
    .d_i(pe_i), .d_f(pe_f), .steps(pe_steps)
  );

  pd_to_steps #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEPS(STEPS), .ERR_W(ERR_W)) u_fe_cv (
    .d_i(fe_i), .d_f(fe_f), .steps(fe_steps)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_i     <= '0;
      acc_f     <= '0;
      prev_i    <= '0;
      prev_f    <= '0;
      ph_err    <= '0;
      fr_err    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      acc_i     <= nacc_i;
      acc_f     <= nacc_f;
      prev_i    <= meas_i;
      prev_f    <= meas_f;
      ph_err    <= pe_steps;
      fr_err    <= fe_steps;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dpll_phase_detector_chk.sv
module dpll_phase_detector_chk #(
  parameter int STEPS  = 40,
  parameter int FRAC_W = 6,
  parameter int ERR_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              lock_load,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ERR_W-1:0]  ph_err,
  input logic [ERR_W-1:0]  fr_err,
  input logic [FRAC_W-1:0] meas_f,
  input logic [FRAC_W-1:0] fcw_frac
);
  AST_FRAC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_f < FRAC_W'(STEPS)); // R2

  AST_FCW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> fcw_frac < FRAC_W'(STEPS)); // R6

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && lock_load) |=> (out_valid && ph_err == '0)); // R8

  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(ph_err) && $stable(fr_err))); // R10

  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
endmodule

bind dpll_phase_detector dpll_phase_detector_chk #(
  .STEPS(STEPS), .FRAC_W(FRAC_W), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .lock_load(lock_load), .out_valid(out_valid), .out_ready(out_ready),
  .ph_err(ph_err), .fr_err(fr_err), .meas_f(meas_f), .fcw_frac(fcw_frac)
);

// File: tb/tb_dpll_phase_detector.sv
`timescale 1ns/1ps
module tb_dpll_phase_detector;
  localparam int M = 256 * 40;
  localparam int H = M / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [7:0]        cnt_smp = '0;
  logic [39:0]       tdc_smp = '0;
  logic [7:0]        fcw_int = '0;
  logic [5:0]        fcw_frac = '0;
  logic              lock_load = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [13:0]       ph_err, fr_err;

  int checks = 0;
  int errors = 0;
  int acc_m = 0;
  int prev_m = 0;
  int exp_pe, exp_fe;

  always #2.5 clk = ~clk;

  dpll_phase_detector dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cnt_smp(cnt_smp), .tdc_smp(tdc_smp), .fcw_int(fcw_int), .fcw_frac(fcw_frac),
    .lock_load(lock_load), .out_valid(out_valid), .out_ready(out_ready),
    .ph_err(ph_err), .fr_err(fr_err)
  );

  function automatic int wrapm(int x);
    int r = x % M;
    if (r < 0) r += M;
    return r;
  endfunction

  function automatic int sgn(int x);
    int r = wrapm(x);
    if (r >= H) r -= M;
    return r;
  endfunction

  task automatic ck(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int p, int fi, int ff, bit load, int bub, bit allones);
    int f = p % 40;
    int i = p / 40;
    cnt_smp = 8'((i + ((f >= 20) ? 1 : 0)) % 256);
    for (int k = 0; k < 40; k++) tdc_smp[k] = (k < f);
    if (bub >= 0) tdc_smp[bub] = ~tdc_smp[bub];
    if (allones) tdc_smp = '1;
    fcw_int   = 8'(fi);
    fcw_frac  = 6'(ff);
    lock_load = load;
    in_valid  = 1'b1;
  endtask

  task automatic model(int p, int fi, int ff, bit load);
    int fcw = fi * 40 + ff;
    int na  = load ? p : wrapm(acc_m + fcw);
    exp_pe = sgn(p - na);
    exp_fe = sgn(p - prev_m - fcw);
    acc_m  = na;
    prev_m = p;
  endtask

  task automatic send(int p, int fi, int ff, bit load, int bub, bit allones,
                      string tp, string tf);
    @(negedge clk);
    drive(p, fi, ff, load, bub, allones);
    model(p, fi, ff, load);
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
    lock_load = 1'b0;
    ck(out_valid == 1'b1, "R9 out_valid after accept", int'(out_valid), 1);
    ck(int'($signed(ph_err)) == exp_pe, tp, int'($signed(ph_err)), exp_pe);
    ck(int'($signed(fr_err)) == exp_fe, tf, int'($signed(fr_err)), exp_fe);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    int fi_l[4] = '{22, 0, 25, 255};
    int ff_l[4] = '{39, 1, 0, 39};
    int pa, pb;
    int hold_pe, hold_fe;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ck(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    ck(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R1: first sample against a zeroed accumulator and previous phase
    send(1234, 22, 20, 1'b0, -1, 1'b0, "R1 ph_err first", "R1 fr_err first");

    // R8: lock reload
    send(5000, 22, 20, 1'b1, -1, 1'b0, "R8 ph_err on reload", "R7 fr_err on reload");

    // R2 R5 R11: every fraction, at a low integer and at the integer wrap
    for (int f = 0; f < 40; f++) begin
      send(3 * 40 + f, 22, 20, 1'b0, -1, 1'b0, "R2 R5 ph_err sweep", "R7 fr_err sweep");
      send(255 * 40 + f, 22, 20, 1'b0, -1, 1'b0, "R5 R11 ph_err wrap sweep", "R11 fr_err wrap sweep");
    end

    @(negedge clk);
    ck(out_valid == 1'b0, "R9 out_valid drops when drained", int'(out_valid), 0);

    // R3: single bubble far from the edge
    for (int f = 0; f < 40; f++)
      send(100 * 40 + f, 7, 5, 1'b0, (f + 20) % 40, 1'b0, "R3 ph_err bubble", "R3 fr_err bubble");

    // R4: saturated snapshot
    send(7 * 40 + 39, 1, 0, 1'b0, -1, 1'b1, "R4 ph_err all ones", "R4 fr_err all ones");

    // R6 R7 R11: tracking with varied command words
    p = 250 * 40 + 10;
    send(p, fi_l[0], ff_l[0], 1'b1, -1, 1'b0, "R8 ph_err track lock", "R7 fr_err track lock");
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 75; j++) begin
        p = wrapm(p + fi_l[s] * 40 + ff_l[s] + ((j * 7) % 11) - 5);
        send(p, fi_l[s], ff_l[s], 1'b0, -1, 1'b0, "R6 R11 ph_err track", "R7 R11 fr_err track");
      end
    end

    // R10 with R8: stall while a reload sample waits
    @(negedge clk);
    out_ready = 1'b0;
    pa = 40 * 40 + 13;
    send(pa, 22, 20, 1'b0, -1, 1'b0, "R10 ph_err before stall", "R10 fr_err before stall");
    hold_pe = exp_pe;
    hold_fe = exp_fe;
    pb = 62 * 40 + 27;
    drive(pb, 22, 20, 1'b1, -1, 1'b0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      ck(in_ready == 1'b0, "R10 in_ready low in stall", int'(in_ready), 0);
      ck(out_valid == 1'b1, "R10 out_valid held in stall", int'(out_valid), 1);
      ck(int'($signed(ph_err)) == hold_pe, "R10 ph_err held", int'($signed(ph_err)), hold_pe);
      ck(int'($signed(fr_err)) == hold_fe, "R10 fr_err held", int'($signed(fr_err)), hold_fe);
    end
    out_ready = 1'b1;
    model(pb, 22, 20, 1'b1);
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
    lock_load = 1'b0;
    ck(int'($signed(ph_err)) == exp_pe, "R8 R10 ph_err after stall", int'($signed(ph_err)), exp_pe);
    ck(int'($signed(fr_err)) == exp_fe, "R10 fr_err after stall", int'($signed(fr_err)), exp_fe);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule